// File: doc/BRIEF.md
# Multi-Lane Configuration Data Streamer

This block turns a stream of 16-bit words into a gated configuration clock and an 8-bit data bus for loading programmable logic. A start pulse latches a lane mode and a total bit count. The block then emits 1, 2, 4 or 8 bits per configuration clock period, beginning with the least significant bits of each word. The configuration clock runs at half the rate of a clock-enable tick from an external divider: every tick is one half period.

Words arrive over a valid/ready interface. The block holds one word at a time. It raises ready only when that word is fully sent and the configuration clock is low. While no word is held, the configuration clock stops low and waits, so a slow memory can throttle a fast clock without stale bits being sent. The source must keep valid and data steady until ready is seen. Ready may stay low for any number of cycles.

After the final bit the clock is parked low and the data bus is driven to all ones. The block keeps counting virtual clock periods so that a sequencer can detect a missing completion response once 64 periods have passed. An abort returns the block to idle in one cycle from any state.

Top module: `cfg_lane_streamer`

## Requirements
- R1: After reset, the configuration clock and all data lines are low, and ready, the last-bit flag and the post-count flag are low.
- R2: The lane mode encodes 0, 1, 2 and 3 as 1, 2, 4 and 8 lanes (n). In each clock period the n lowest unsent bits of the current word appear on data[n-1:0], with the lowest bit on data[0].
- R3: While streaming, data lines at and above n are driven low.
- R4: Data changes only together with a falling edge of the configuration clock, so it stays steady for the whole high phase.
- R5: The configuration clock never rises while no word is held. With no input word available it stays low, and it resumes once a word arrives.
- R6: A word is accepted only after all 16 bits of the previous word have been sent. Ready is high only while streaming, with the buffer empty and the configuration clock low.
- R7: The configuration clock rises only in a cycle in which the tick input is high.
- R8: Exactly total/n rising edges are produced. After the last falling edge the clock stays low, data reads 0xFF, the last-bit flag is high and ready is low.
- R9: The mode and total-count inputs are sampled at start only. Changes to them while streaming have no effect.
- R10: An abort returns the block to idle by the next cycle: the clock is low, data is 0, ready and the last-bit flag are low, and the held word is discarded, so the next stream starts from its own first word.
- R11: After the last bit, every two ticks count one clock period. The post-count flag rises once 64 periods are counted and stays high until the next start or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Half-period enable for the configuration clock |
| start_i | input | 1 | Begin a stream (honoured when not streaming) |
| abort_i | input | 1 | Return to idle and discard the held word |
| mode_i | input | 2 | Lane mode: 0=1, 1=2, 2=4, 3=8 lanes |
| total_bits_i | input | 24 | Number of bits to send in this stream |
| in_valid_i | input | 1 | Source word valid |
| in_data_i | input | 16 | Source word |
| in_ready_o | output | 1 | Block can take a word this cycle |
| dclk_o | output | 1 | Gated configuration clock |
| data_o | output | 8 | Configuration data lanes |
| last_sent_o | output | 1 | Final bit has been sent |
| post_hit_o | output | 1 | 64 periods have elapsed since the final bit |

## Verification
The assertions assume certain things about the inputs. The total bit count must be a nonzero multiple of the lane count, and it must not exceed the bits that the supplied words carry. The source must hold valid and data steady once it raises valid. Start and abort must be single-cycle pulses. The stimulus drives all inputs on the falling system clock edge and follows these rules. It chooses counts that divide by the lane count, including counts that end partway through a word. It inserts idle gaps only after a word has been accepted, and it flips the mode input only after start has been sampled.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } stream_st_e;

  // lanes active for a given mode code: 1 << code
  function automatic uint_t lanes_of(input uint_t code);
    return uint_t'(1) << code;
  endfunction
endpackage

// File: rtl/cls_word_buf.sv
module cls_word_buf
  import cls_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 8,
  parameter int MODE_W = 2,
  localparam int CW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [LANES-1:0]  lanes_o,
  output logic [CW-1:0]     count_o
);
  logic [WORD_W-1:0] buf_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     step;

  assign step = CW'(lanes_of(uint_t'(mode_i)));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      buf_q <= word_i;
      cnt_q <= CW'(WORD_W);
    end else if (shift_i) begin
      buf_q <= buf_q >> step;
      cnt_q <= cnt_q - step;
    end
  end

  assign lanes_o = buf_q[LANES-1:0];
  assign count_o = cnt_q;

  // R6: a load only lands in an empty buffer and fills it completely
  a_r6_load_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> cnt_q == '0);
  a_r6_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> cnt_q == CW'(WORD_W));
  // R5: a shift never consumes bits that are not held
  a_r5_shift_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> cnt_q >= step);
endmodule

// File: rtl/cls_lane_mux.sv
module cls_lane_mux
  import cls_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LANES-1:0]  bits_i,
  input  logic              run_i,
  input  logic              done_i,
  output logic [LANES-1:0]  data_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_on;
    assign lane_on   = uint_t'(i) < lanes_of(uint_t'(mode_i));
    assign data_o[i] = done_i | (run_i & lane_on & bits_i[i]);
  end
endmodule

// File: rtl/cls_post_counter.sv
module cls_post_counter #(
  parameter int LIMIT = 64,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic hit_o
);
  logic          phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en_i && tick_i) begin
      phase_q <= ~phase_q;
      if (phase_q && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = cnt_q == CW'(LIMIT);

  // R11: the flag saturates until cleared
  a_r11_hit_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !clr_i) |=> hit_o);
  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/cfg_lane_streamer.sv
module cfg_lane_streamer
  import cls_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int LANES      = 8,
  parameter int CNT_W      = 24,
  parameter int POST_LIMIT = 64,
  localparam int MODE_W    = $clog2($clog2(LANES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  total_bits_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              dclk_o,
  output logic [LANES-1:0]  data_o,
  output logic              last_sent_o,
  output logic              post_hit_o
);
  localparam int CW = $clog2(WORD_W + 1);

  stream_st_e        st_q;
  logic              dclk_q;
  logic [CNT_W-1:0]  rem_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  step;
  logic [LANES-1:0]  buf_lanes;
  logic [CW-1:0]     buf_cnt;
  logic              take, rise_go, fall_go, last_go, start_go;

  assign step     = CNT_W'(lanes_of(uint_t'(mode_q)));
  assign start_go = start_i && !abort_i && st_q != ST_RUN;
  assign take     = in_valid_i && in_ready_o;
  assign rise_go  = st_q == ST_RUN && tick_i && !dclk_q && buf_cnt != '0;
  assign fall_go  = st_q == ST_RUN && tick_i && dclk_q;
  assign last_go  = fall_go && rem_q == step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dclk_q <= 1'b0;
      rem_q  <= '0;
      mode_q <= '0;
    end else if (abort_i) begin
      st_q   <= ST_IDLE;
      dclk_q <= 1'b0;
    end else if (start_go) begin
      st_q   <= (total_bits_i == '0) ? ST_DONE : ST_RUN;
      dclk_q <= 1'b0;
      rem_q  <= total_bits_i;
      mode_q <= mode_i;
    end else if (rise_go) begin
      dclk_q <= 1'b1;
    end else if (fall_go) begin
      dclk_q <= 1'b0;
      rem_q  <= rem_q - step;
      if (last_go) st_q <= ST_DONE;
    end
  end

  cls_word_buf #(.WORD_W(WORD_W), .LANES(LANES), .MODE_W(MODE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (abort_i || start_go),
    .load_i  (take && !abort_i),
    .word_i  (in_data_i),
    .shift_i (fall_go && !abort_i),
    .mode_i  (mode_q),
    .lanes_o (buf_lanes),
    .count_o (buf_cnt)
  );

  cls_lane_mux #(.LANES(LANES), .MODE_W(MODE_W)) u_mux (
    .mode_i (mode_q),
    .bits_i (buf_lanes),
    .run_i  (st_q == ST_RUN),
    .done_i (st_q == ST_DONE),
    .data_o (data_o)
  );

  cls_post_counter #(.LIMIT(POST_LIMIT)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (abort_i || start_go),
    .en_i   (st_q == ST_DONE),
    .tick_i (tick_i),
    .hit_o  (post_hit_o)
  );

  assign in_ready_o  = st_q == ST_RUN && buf_cnt == '0 && !dclk_q;
  assign dclk_o      = dclk_q;
  assign last_sent_o = st_q == ST_DONE;

  // R7: clock rises only on a tick
  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_q) |-> $past(tick_i));
  // R5: clock rises only with a held word
  a_r5_rise_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_q) |-> $past(buf_cnt) != '0);
  // R4: data is steady through the high phase
  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_q && $past(dclk_q)) |-> $stable(data_o));
  // R3: lanes above n are low while streaming
  a_r3_upper_lanes_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (data_o >> lanes_of(uint_t'(mode_q))) == '0);
  // R6: ready never overlaps a high clock
  a_r6_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> !dclk_q);
  // R8: parked state after the last bit
  a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
    last_sent_o |-> (!dclk_q && data_o == '1 && !in_ready_o));
  // R10: abort clears within one cycle
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!dclk_q && !last_sent_o && buf_cnt == '0 && !in_ready_o));
endmodule

// File: tb/cfg_lane_streamer_test.sv
module cfg_lane_streamer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [23:0] total = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, dclk, last_sent, post_hit;
  logic [7:0]  data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_lane_streamer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .abort_i(abort),
    .mode_i(mode), .total_bits_i(total), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .dclk_o(dclk), .data_o(data),
    .last_sent_o(last_sent), .post_hit_o(post_hit)
  );

  // source
  logic [15:0] words [0:7];
  int  nwords = 0, idx = 0, gap_len = 0, gap_cnt = 0;
  bit  src_on = 1'b0, took = 1'b0;

  always @(negedge clk) begin
    if (!src_on) begin
      in_valid = 1'b0;
      took = 1'b0;
      gap_cnt = 0;
    end else begin
      if (took) begin
        idx = idx + 1;
        gap_cnt = gap_len;
      end else if (gap_cnt > 0 && !in_valid) begin
        gap_cnt = gap_cnt - 1;
      end
      in_valid = (gap_cnt == 0) && (idx < nwords);
      in_data  = words[idx % 8];
      took = in_valid && in_ready;
    end
  end

  // monitor and tick pacing
  logic [7:0] cap [0:255];
  int  ncap = 0, rise_err = 0, stable_err = 0, ready_err = 0, tick_div = 1, cyc = 0;
  logic prev_dclk = 1'b0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (dclk && !prev_dclk) begin
        if (ncap < 256) cap[ncap] = data;
        ncap = ncap + 1;
        if (!tick) rise_err = rise_err + 1;
      end
      if (dclk && prev_dclk && data != prev_data) stable_err = stable_err + 1;
      if (in_ready && dclk) ready_err = ready_err + 1;
    end
    prev_dclk = dclk;
    prev_data = data;
    tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // start a stream and wait for completion, then verify captured lanes
  task automatic run_stream(input int m, input int bits, input int nw, input int gap,
                            input bit flip_mode);
    int n, b, w, expv, waited;
    n = 1 << m;
    @(negedge clk);
    src_on = 1'b0;
    @(negedge clk);
    nwords = nw; idx = 0; gap_len = gap;
    ncap = 0; rise_err = 0; stable_err = 0; ready_err = 0;
    mode = 2'(m); total = 24'(bits);
    start = 1'b1; src_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flip_mode) begin mode = ~2'(m); total = 24'd8; end
    waited = 0;
    while (!last_sent && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(last_sent, "R8 last flag", int'(last_sent), 1);
    chk(ncap == bits / n, "R8 rise count", ncap, bits / n);
    for (int k = 0; k < ncap && k < 256; k++) begin
      b = k * n;
      w = int'(words[b / 16]);
      expv = (w >> (b % 16)) & ((1 << n) - 1);
      chk(int'(cap[k]) == expv, flip_mode ? "R9 lane data" : "R2 lane data", int'(cap[k]), expv);
      chk((int'(cap[k]) >> n) == 0, "R3 upper lanes", int'(cap[k]) >> n, 0);
    end
    chk(stable_err == 0, "R4 data steady in high phase", stable_err, 0);
    chk(ready_err == 0, "R6 ready with clock high", ready_err, 0);
    chk(rise_err == 0, "R7 rise without tick", rise_err, 0);
    chk(dclk == 1'b0 && data == 8'hFF, "R8 parked outputs", {dclk, data}, 9'h0FF);
    chk(in_ready == 1'b0, "R8 ready low when done", int'(in_ready), 0);
    src_on = 1'b0;
  endtask

  task automatic t_reset();
    chk(dclk == 0 && data == 0, "R1 clock and data", {dclk, data}, 0);
    chk(!in_ready && !last_sent && !post_hit, "R1 flags", {in_ready, last_sent, post_hit}, 0);
  endtask

  task automatic t_serial();
    words[0] = 16'hA5C3; words[1] = 16'h1234;
    run_stream(0, 32, 2, 0, 1'b0);
  endtask

  task automatic t_byte_stall();
    int first_wait;
    words[0] = 16'hBEEF; words[1] = 16'h0F1E; words[2] = 16'h8001;
    run_stream(3, 48, 3, 6, 1'b1);
    // R5: six rises over three words spaced by gaps; no extra rises happened
    first_wait = ncap;
    chk(first_wait == 6, "R5 no rises during stall", first_wait, 6);
  endtask

  task automatic t_mid_lanes();
    words[0] = 16'h6C39; words[1] = 16'hF00D;
    run_stream(1, 20, 2, 2, 1'b0);
    words[0] = 16'h1357; words[1] = 16'h9ACE;
    run_stream(2, 24, 2, 0, 1'b0);
  endtask

  task automatic t_pace();
    tick_div = 3;
    words[0] = 16'h4B2D; words[1] = 16'hE871;
    run_stream(2, 32, 2, 1, 1'b0);
    tick_div = 1;
  endtask

  task automatic t_post();
    words[0] = 16'h00FF;
    run_stream(3, 16, 1, 0, 1'b0);
    repeat (100) @(negedge clk);
    chk(post_hit == 1'b0, "R11 not yet at 50 periods", int'(post_hit), 0);
    repeat (40) @(negedge clk);
    chk(post_hit == 1'b1, "R11 flag at 64 periods", int'(post_hit), 1);
    repeat (200) @(negedge clk);
    chk(post_hit == 1'b1 && last_sent, "R11 flag saturates", int'(post_hit), 1);
  endtask

  task automatic t_abort();
    int waited;
    // abort from the parked state
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!last_sent && !post_hit && dclk == 0 && data == 0, "R10 abort from done",
        {last_sent, post_hit, dclk, data}, 0);
    // abort mid-stream with a partly sent word held
    words[0] = 16'hFFFF; words[1] = 16'hFFFF; words[2] = 16'hFFFF;
    nwords = 3; idx = 0; gap_len = 0; ncap = 0;
    mode = 2'd0; total = 24'd48;
    start = 1'b1; src_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (ncap < 3 && waited < 1000) begin @(negedge clk); waited++; end
    abort = 1'b1; src_on = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    chk(dclk == 0 && data == 0 && !in_ready && !last_sent, "R10 idle after abort",
        {dclk, data, in_ready, last_sent}, 0);
    repeat (5) @(negedge clk);
    chk(dclk == 0 && ncap == 3, "R10 no clock after abort", ncap, 3);
    // next stream must start with its own word, not the leftover ones
    words[0] = 16'h0002;
    run_stream(0, 16, 1, 0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_byte_stall();
    t_mid_lanes();
    t_pace();
    t_post();
    t_abort();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule